// File: doc/BRIEF.md
# Local Configuration and I/O Request Screen

This block sits on the inbound request path of a link tunnel. It looks at each request descriptor aimed at the tunnel and sorts it into one of four outcomes. A request that does not hit the tunnel's own configuration space, I/O space or bridge functions is handed back to the forwarding path untouched. A posted request that hits local space is discarded quietly. A nonposted single-doubleword read or write that is aligned to a doubleword boundary is passed to the register interface. Any other local request is dropped and answered with a target-abort response.

Each request is presented for one cycle with `req_valid`. Exactly one outcome appears on the outputs in the next cycle. The register interface receives the doubleword index of the address and the byte enables unchanged. The response side says whether a read-type response or a write-completion response must be built. Target-abort responses never carry a data payload.

Top module: `cfg_io_req_screen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `reg_valid`, `drop_valid`, `fwd_valid` and `rsp_valid` are low and `rsp_status` is 2'b00.
- R2: A local nonposted read (`req_kind`=2'b00) or write (`req_kind`=2'b01) with `req_len`=0 (one doubleword) and `req_addr[1:0]`=0 raises `reg_valid` one cycle later. In that cycle `reg_write` is set for a write, `reg_addr` equals `req_addr[ADDR_W-1:2]`, and `reg_be` equals `req_be`.
- R3: A local nonposted read or write with `req_len` nonzero (more than one doubleword) raises `drop_valid` and `rsp_valid` one cycle later, with `rsp_status`=2'b10 (target abort). `rsp_read` is 1 for a read and 0 for a write.
- R4: A local nonposted read or write with `req_addr[1:0]` nonzero is outside a single aligned 32-bit block and is answered as in R3.
- R5: A local nonposted atomic read-modify-write (`req_kind`=2'b10) is dropped with a target-abort response that has `rsp_read`=1, whatever its length or address.
- R6: A request with `req_local`=0 raises only `fwd_valid` one cycle later, whatever its kind, posting, length or address.
- R7: A local posted request of any kind raises only `drop_valid` one cycle later, with no response.
- R8: Each presented request produces exactly one of accept, drop or forward, in the next cycle only. A cycle without `req_valid` produces none of them in the following cycle, and back-to-back requests give back-to-back outcomes.
- R9: A local nonposted request with the reserved kind 2'b11 is dropped with a target-abort response that has `rsp_read`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request descriptor present this cycle |
| req_local | input | 1 | Request targets local configuration, I/O or bridge space |
| req_posted | input | 1 | 1 = posted, 0 = nonposted |
| req_kind | input | 2 | 00 read, 01 write, 10 atomic read-modify-write, 11 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Length in doublewords minus one |
| req_be | input | BE_W | Byte enables |
| reg_valid | output | 1 | Access passed to the register interface |
| reg_write | output | 1 | Accepted access is a write |
| reg_addr | output | ADDR_W-2 | Doubleword index of the accepted access |
| reg_be | output | BE_W | Byte enables of the accepted access |
| drop_valid | output | 1 | Request discarded |
| rsp_valid | output | 1 | Response must be generated for the dropped request |
| rsp_read | output | 1 | 1 = read-type response, 0 = write completion |
| rsp_status | output | 2 | 10 = target abort, 00 otherwise |
| fwd_valid | output | 1 | Request returned to the forwarding path unchanged |

## Verification
A wrong priority or a wrong length or alignment decode in the classifier shows up one cycle after the request. It appears as the wrong one of `reg_valid`, `drop_valid` or `fwd_valid`, or as a response raised or missing. A stale or wrongly enabled data register shows up in the same cycle as a wrong `reg_addr`, `reg_be`, `reg_write` or `rsp_read`. A held valid register shows up one cycle later as an outcome in a cycle that had no request. Every decision is made again for each request, so no fault can stay hidden for more than the one request that exercises it.

// File: rtl/cfg_screen_pkg.sv
package cfg_screen_pkg;

  typedef enum logic [1:0] {
    KIND_RD   = 2'b00,
    KIND_WR   = 2'b01,
    KIND_ATOM = 2'b10,
    KIND_RSVD = 2'b11
  } req_kind_e;

  typedef enum logic [2:0] {
    VD_NONE   = 3'd0,
    VD_ACCEPT = 3'd1,
    VD_SILENT = 3'd2,
    VD_ABORT  = 3'd3,
    VD_FWD    = 3'd4
  } verdict_e;

  localparam logic [1:0] STS_NORMAL    = 2'b00;
  localparam logic [1:0] STS_TGT_ABORT = 2'b10;

endpackage

// File: rtl/cfg_screen_rst_sync.sv
module cfg_screen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_screen_classify.sv
module cfg_screen_classify
  import cfg_screen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int BE_W   = 4
) (
  input  logic              req_valid,
  input  logic              req_local,
  input  logic              req_posted,
  input  req_kind_e         req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output verdict_e          verdict,
  output logic              rsp_read
);

  localparam int OFF_W = $clog2(BE_W);

  logic single_dw;
  logic aligned;

  assign single_dw = (req_len == '0);
  assign aligned   = (req_addr[OFF_W-1:0] == '0);

  // Priority: remote, posted, atomic/reserved, length, alignment.
  always_comb begin
    verdict = VD_NONE;
    if (req_valid) begin
      if (!req_local)                                     verdict = VD_FWD;
      else if (req_posted)                                verdict = VD_SILENT;
      else if (req_kind == KIND_ATOM || req_kind == KIND_RSVD) verdict = VD_ABORT;
      else if (!single_dw || !aligned)                    verdict = VD_ABORT;
      else                                                verdict = VD_ACCEPT;
    end
  end

  assign rsp_read = (req_kind == KIND_RD) || (req_kind == KIND_ATOM);

endmodule

// File: rtl/cfg_screen_outreg.sv
module cfg_screen_outreg
  import cfg_screen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  verdict_e                 verdict,
  input  logic                     in_write,
  input  logic                     in_rsp_read,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [BE_W-1:0]          in_be,
  output logic                     reg_valid,
  output logic                     reg_write,
  output logic [ADDR_W-$clog2(BE_W)-1:0] reg_addr,
  output logic [BE_W-1:0]          reg_be,
  output logic                     drop_valid,
  output logic                     rsp_valid,
  output logic                     rsp_read,
  output logic [1:0]               rsp_status,
  output logic                     fwd_valid
);

  localparam int OFF_W = $clog2(BE_W);
  localparam int DW_AW = ADDR_W - OFF_W;

  logic             reg_valid_d, drop_valid_d, rsp_valid_d, fwd_valid_d;
  logic [1:0]       rsp_status_d;
  logic             acc_ld, rsp_ld;

  always_comb begin
    reg_valid_d  = (verdict == VD_ACCEPT);
    drop_valid_d = (verdict == VD_SILENT) || (verdict == VD_ABORT);
    rsp_valid_d  = (verdict == VD_ABORT);
    fwd_valid_d  = (verdict == VD_FWD);
    rsp_status_d = rsp_valid_d ? STS_TGT_ABORT : STS_NORMAL;
    acc_ld       = reg_valid_d;
    rsp_ld       = rsp_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_valid  <= 1'b0;
      drop_valid <= 1'b0;
      rsp_valid  <= 1'b0;
      fwd_valid  <= 1'b0;
      rsp_status <= STS_NORMAL;
    end else begin
      reg_valid  <= reg_valid_d;
      drop_valid <= drop_valid_d;
      rsp_valid  <= rsp_valid_d;
      fwd_valid  <= fwd_valid_d;
      rsp_status <= rsp_status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_write <= 1'b0;
      reg_addr  <= '0;
      reg_be    <= '0;
    end else if (acc_ld) begin
      reg_write <= in_write;
      reg_addr  <= in_addr[ADDR_W-1:OFF_W];
      reg_be    <= in_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_read <= 1'b0;
    else if (rsp_ld) rsp_read <= in_rsp_read;
  end

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_valid, drop_valid, fwd_valid}));

  // R3
  rsp_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (drop_valid && rsp_status == STS_TGT_ABORT));

  // R1
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_status == STS_NORMAL));

  logic [DW_AW-1:0] unused_w;
  assign unused_w = '0;

endmodule

// File: rtl/cfg_io_req_screen.sv
module cfg_io_req_screen
  import cfg_screen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int BE_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_local,
  input  logic                     req_posted,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [BE_W-1:0]          req_be,
  output logic                     reg_valid,
  output logic                     reg_write,
  output logic [ADDR_W-$clog2(BE_W)-1:0] reg_addr,
  output logic [BE_W-1:0]          reg_be,
  output logic                     drop_valid,
  output logic                     rsp_valid,
  output logic                     rsp_read,
  output logic [1:0]               rsp_status,
  output logic                     fwd_valid
);

  logic      rst_sync_n;
  verdict_e  verdict;
  logic      cls_rsp_read;
  req_kind_e kind;

  assign kind = req_kind_e'(req_kind);

  cfg_screen_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfg_screen_classify #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BE_W(BE_W)) i_classify (
    .req_valid  (req_valid),
    .req_local  (req_local),
    .req_posted (req_posted),
    .req_kind   (kind),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .verdict    (verdict),
    .rsp_read   (cls_rsp_read)
  );

  cfg_screen_outreg #(.ADDR_W(ADDR_W), .BE_W(BE_W)) i_outreg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .verdict     (verdict),
    .in_write    (kind == KIND_WR),
    .in_rsp_read (cls_rsp_read),
    .in_addr     (req_addr),
    .in_be       (req_be),
    .reg_valid   (reg_valid),
    .reg_write   (reg_write),
    .reg_addr    (reg_addr),
    .reg_be      (reg_be),
    .drop_valid  (drop_valid),
    .rsp_valid   (rsp_valid),
    .rsp_read    (rsp_read),
    .rsp_status  (rsp_status),
    .fwd_valid   (fwd_valid)
  );

  // R7
  posted_silent_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_local && req_posted) |=> (drop_valid && !rsp_valid));

  // R6
  remote_fwd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_local) |=> (fwd_valid && !reg_valid && !drop_valid));

  // R2
  be_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_local && !req_posted && req_kind == 2'b00 && req_len == '0
     && req_addr[1:0] == 2'b00) |=> (reg_valid && reg_be == $past(req_be)));

  // R5
  atomic_abort_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_local && !req_posted && req_kind == 2'b10) |=> (rsp_valid && rsp_read));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !(reg_valid || drop_valid || fwd_valid));

endmodule

// File: tb/test_cfg_io_req_screen.sv
`timescale 1ns/1ps
module test_cfg_io_req_screen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_local, req_posted;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic [3:0]  req_len, req_be;
  logic        reg_valid, reg_write, drop_valid, rsp_valid, rsp_read, fwd_valid;
  logic [29:0] reg_addr;
  logic [3:0]  reg_be;
  logic [1:0]  rsp_status;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_io_req_screen i_cfg_io_req_screen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_local(req_local),
    .req_posted(req_posted), .req_kind(req_kind), .req_addr(req_addr),
    .req_len(req_len), .req_be(req_be), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_be(reg_be),
    .drop_valid(drop_valid), .rsp_valid(rsp_valid), .rsp_read(rsp_read),
    .rsp_status(rsp_status), .fwd_valid(fwd_valid)
  );

  // {req[3:0], local, posted, kind[1:0], addr[31:0], len[3:0], be[3:0], exp[2:0], rsp_read}
  // exp: 1 accept, 2 silent drop, 3 target abort, 4 forward
  localparam int NV = 15;
  localparam logic [51:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b0, 2'd0, 32'h0000_0040, 4'd0,  4'hF, 3'd1, 1'b0}, // R2 read
    {4'd2, 1'b1, 1'b0, 2'd1, 32'h0000_1234, 4'd0,  4'h5, 3'd1, 1'b0}, // R2 write
    {4'd2, 1'b1, 1'b0, 2'd1, 32'hFFFF_FFFC, 4'd0,  4'h8, 3'd1, 1'b0}, // R2 top
    {4'd3, 1'b1, 1'b0, 2'd0, 32'h0000_0040, 4'd1,  4'hF, 3'd3, 1'b1}, // R3 read 2 DW
    {4'd3, 1'b1, 1'b0, 2'd1, 32'h0000_0080, 4'd15, 4'hF, 3'd3, 1'b0}, // R3 write 16 DW
    {4'd4, 1'b1, 1'b0, 2'd0, 32'h0000_0042, 4'd0,  4'h3, 3'd3, 1'b1}, // R4 read
    {4'd4, 1'b1, 1'b0, 2'd1, 32'h0000_0043, 4'd0,  4'h1, 3'd3, 1'b0}, // R4 write
    {4'd5, 1'b1, 1'b0, 2'd2, 32'h0000_0010, 4'd0,  4'hF, 3'd3, 1'b1}, // R5
    {4'd5, 1'b1, 1'b0, 2'd2, 32'h0000_0011, 4'd1,  4'hF, 3'd3, 1'b1}, // R5 odd
    {4'd6, 1'b0, 1'b0, 2'd2, 32'h0000_0010, 4'd0,  4'hF, 3'd4, 1'b0}, // R6 atomic
    {4'd6, 1'b0, 1'b0, 2'd0, 32'h0000_0047, 4'd3,  4'h2, 3'd4, 1'b0}, // R6 read
    {4'd6, 1'b0, 1'b1, 2'd1, 32'h0000_0100, 4'd7,  4'hF, 3'd4, 1'b0}, // R6 posted
    {4'd7, 1'b1, 1'b1, 2'd1, 32'h0000_0040, 4'd0,  4'hF, 3'd2, 1'b0}, // R7 write
    {4'd7, 1'b1, 1'b1, 2'd2, 32'h0000_0040, 4'd0,  4'hF, 3'd2, 1'b0}, // R7 atomic
    {4'd9, 1'b1, 1'b0, 2'd3, 32'h0000_0040, 4'd0,  4'hF, 3'd3, 1'b0}  // R9
  };

  task automatic drive(input logic [51:0] v);
    req_valid  = 1'b1;
    req_local  = v[47];
    req_posted = v[46];
    req_kind   = v[45:44];
    req_addr   = v[43:12];
    req_len    = v[11:8];
    req_be     = v[7:4];
  endtask

  task automatic idle();
    req_valid = 1'b0; req_local = 1'b0; req_posted = 1'b0; req_kind = 2'd0;
    req_addr = '0; req_len = '0; req_be = '0;
  endtask

  task automatic check_vec(input logic [51:0] v);
    logic [3:0] exp_flags;
    logic [3:0] got;
    checks++;
    case (v[3:1])
      3'd1: exp_flags = 4'b1000;
      3'd2: exp_flags = 4'b0100;
      3'd3: exp_flags = 4'b0101;
      default: exp_flags = 4'b0010;
    endcase
    got = {reg_valid, drop_valid, fwd_valid, rsp_valid};
    if (got !== exp_flags) begin
      failures++;
      $display("FAIL R%0d outcome got=%b exp=%b", v[51:48], got, exp_flags);
    end
    if (v[3:1] == 3'd1) begin
      checks++;
      if (reg_write !== (v[45:44] == 2'd1) || reg_addr !== v[43:14] || reg_be !== v[7:4]) begin
        failures++;
        $display("FAIL R2 reg fields got=%b/%h/%h exp=%b/%h/%h", reg_write, reg_addr,
                 reg_be, (v[45:44] == 2'd1), v[43:14], v[7:4]);
      end
    end
    if (v[3:1] == 3'd3) begin
      checks++;
      if (rsp_read !== v[0] || rsp_status !== 2'b10) begin
        failures++;
        $display("FAIL R%0d response got=%b/%b exp=%b/10", v[51:48], rsp_read, rsp_status, v[0]);
      end
    end else begin
      checks++;
      if (rsp_status !== 2'b00) begin
        failures++;
        $display("FAIL R%0d status got=%b exp=00", v[51:48], rsp_status);
      end
    end
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if ({reg_valid, drop_valid, fwd_valid, rsp_valid} !== 4'b0000 || rsp_status !== 2'b00) begin
      failures++;
      $display("FAIL %s quiet got=%b/%b exp=0000/00", tag,
               {reg_valid, drop_valid, fwd_valid, rsp_valid}, rsp_status);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check_quiet("R1");
    // R1: request held during reset has no effect
    drive(VEC[0]);
    @(negedge clk);
    check_quiet("R1");
    idle();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check_vec(VEC[i]);
      idle();
      @(negedge clk);
      check_quiet("R8");
    end

    // R8: back-to-back requests give back-to-back outcomes
    drive(VEC[1]);
    @(negedge clk);
    check_vec(VEC[1]);
    drive(VEC[7]);
    @(negedge clk);
    check_vec(VEC[7]);
    drive(VEC[10]);
    @(negedge clk);
    check_vec(VEC[10]);
    drive(VEC[0]);
    @(negedge clk);
    check_vec(VEC[0]);
    idle();
    @(negedge clk);
    check_quiet("R8");

    // R1: reset in mid-run clears outputs
    drive(VEC[3]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_quiet("R1");
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_quiet("R1");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule